// File: doc/BRIEF.md
# Supply-Good Monitor with Asymmetric Delays

This block turns three supply comparator flags into two status outputs: a channel-OK flag (`chan_ok_o`) and an operating flag (`running_o`). The flags report the supply below the warning level (15 V), below the operating floor (10 V) and above the restart level (18 V). The channel-OK output drops only after the supply has stayed below the warning level for the short delay (1 ms). It rises again only after the supply has stayed clean for the long delay (6 ms). Any dip during that long wait starts the wait again from zero.

A sample of the floor flag puts the block into a stopped state from any state. In the stopped state both outputs are low. The warning flag clearing does not bring the block out of this state. Only the restart flag does that, and the long delay then runs before channel-OK asserts. Reset also puts the block in the stopped state.

Both delays are counted in clock cycles, derived from a clock-frequency parameter and two delay parameters in milliseconds. A bench can therefore use a very low nominal frequency to get short delays. In the text below, F = FALL_MS·CLK_HZ/1000 and R = RISE_MS·CLK_HZ/1000. All flags are active high and sampled on the rising clock edge.

Top module: `supply_good_monitor`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `chan_ok_o` and `running_o` are both 0.
- R2: A rising edge that samples `below_floor_i` = 1 makes both outputs 0 from that edge on, whatever the state and the other flags.
- R3: While stopped, an edge that samples `above_restart_i` = 1 and `below_floor_i` = 0 sets `running_o` to 1. If `below_warn_i` stays 0 on the next R edges, `chan_ok_o` rises on the R-th of them. While stopped, `below_warn_i` = 0 alone changes nothing.
- R4: With `chan_ok_o` = 1, `chan_ok_o` goes to 0 on the (F+1)-th consecutive edge that samples `below_warn_i` = 1. A run of F or fewer such edges leaves `chan_ok_o` at 1 throughout.
- R5: While running with `chan_ok_o` = 0, `chan_ok_o` goes to 1 on the (R+1)-th consecutive edge that samples `below_warn_i` = 0. Any edge that samples `below_warn_i` = 1 during the wait restarts the count from zero.
- R6: `chan_ok_o` = 1 only while `running_o` = 1.
- R7: F and R are computed from the parameters CLK_HZ, FALL_MS and RISE_MS as defined above, and each must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| below_warn_i | input | 1 | Supply below warning level (15 V) |
| below_floor_i | input | 1 | Supply below operating floor (10 V) |
| above_restart_i | input | 1 | Supply above restart level (18 V) |
| chan_ok_o | output | 1 | Channel-OK status, high when supply is good |
| running_o | output | 1 | High unless the block is stopped |

## Verification
The hardest case to reach is a dip that arrives exactly at the last cycle of the long recovery wait. It must cancel the recovery by one cycle, and a dip one cycle shorter than the fall threshold must leave the output untouched. The bench sweeps the position of a one-cycle dip across every cycle of the recovery window. It also sweeps dip lengths from one cycle past the fall threshold. It applies the floor flag in each of the five states, and it follows with a long pseudo-random flag run. Each run is checked cycle by cycle against a model built from consecutive-sample counts.

// File: rtl/supply_good_monitor.sv
module supply_good_monitor #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int FALL_MS = 1,
  parameter int RISE_MS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_warn_i,
  input  logic below_floor_i,
  input  logic above_restart_i,
  output logic chan_ok_o,
  output logic running_o
);

  localparam int FALL_CYC = FALL_MS * (CLK_HZ / 1000);
  localparam int RISE_CYC = RISE_MS * (CLK_HZ / 1000);
  localparam int MAX_CYC  = (FALL_CYC > RISE_CYC) ? FALL_CYC : RISE_CYC;
  localparam int CW       = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYC - 1);

  typedef enum logic [2:0] {ST_OFF, ST_RISE, ST_OK, ST_FALL, ST_LOW} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  initial begin
    // R7
    delay_param_chk: assert (FALL_CYC >= 1 && RISE_CYC >= 1)
      else $error("delay parameters give zero cycles");
  end

  always_comb begin
    st_nx  = st;
    cnt_nx = '0;
    if (below_floor_i) begin
      st_nx = ST_OFF;
    end else begin
      unique case (st)
        ST_OFF:  if (above_restart_i) st_nx = ST_RISE;
        ST_RISE: if (below_warn_i)        st_nx = ST_LOW;
                 else if (cnt == RISE_LAST) st_nx = ST_OK;
                 else                       cnt_nx = cnt + 1'b1;
        ST_OK:   if (below_warn_i) st_nx = ST_FALL;
        ST_FALL: if (!below_warn_i)       st_nx = ST_OK;
                 else if (cnt == FALL_LAST) st_nx = ST_LOW;
                 else                       cnt_nx = cnt + 1'b1;
        ST_LOW:  if (!below_warn_i) st_nx = ST_RISE;
        default: st_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_OFF;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign chan_ok_o = (st == ST_OK) || (st == ST_FALL);
  assign running_o = (st != ST_OFF);

  // R6
  ok_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_ok_o |-> running_o);

  // R2
  floor_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_floor_i |=> (!running_o && !chan_ok_o));

  // R3
  restart_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_o) |-> $past(above_restart_i));

  // R5
  rise_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_ok_o) |-> !$past(below_warn_i));

  // R4
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(chan_ok_o) && running_o) |-> $past(below_warn_i));

  // R5
  timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RISE) |-> (cnt <= RISE_LAST));

endmodule

// File: tb/test_supply_good_monitor.sv
module test_supply_good_monitor;
  localparam int CLK_HZ = 4000;
  localparam int F = 1 * (CLK_HZ / 1000);
  localparam int R = 6 * (CLK_HZ / 1000);

  logic clk = 0, rst_n = 0;
  logic warn = 0, floor_f = 0, restart = 0;
  logic ok, run;

  int compared = 0, mismatched = 0;
  string tag = "R1";

  bit m_run, m_ok;
  int m_c;

  always #2 clk = ~clk;

  supply_good_monitor #(.CLK_HZ(CLK_HZ), .FALL_MS(1), .RISE_MS(6)) i_supply_good_monitor (
    .clk(clk), .rst_n(rst_n), .below_warn_i(warn), .below_floor_i(floor_f),
    .above_restart_i(restart), .chan_ok_o(ok), .running_o(run));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ok = 0; m_c = 0;
    end else if (floor_f) begin
      m_run = 0; m_ok = 0; m_c = 0;
    end else if (!m_run) begin
      if (restart) begin m_run = 1; m_c = 1; end
    end else if (m_ok) begin
      if (warn) begin
        m_c++;
        if (m_c == F + 1) begin m_ok = 0; m_c = 0; end
      end else m_c = 0;
    end else begin
      if (!warn) begin
        m_c++;
        if (m_c == R + 1) begin m_ok = 1; m_c = 0; end
      end else m_c = 0;
    end
  end

  task automatic chk();
    compared++;
    if (ok !== m_ok || run !== m_run) begin
      mismatched++;
      $display("FAIL %s t=%0t ok/run actual %b%b expected %b%b", tag, $time, ok, run, m_ok, m_run);
    end
  endtask

  task automatic drive(input bit w, input bit f, input bit r, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk();
      warn = w; floor_f = f; restart = r;
    end
  endtask

  task automatic start_up();
    drive(0, 1, 0, 1);
    drive(0, 0, 1, 1);
    drive(0, 0, 0, R + 3);
  endtask

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tag = "R1";
    drive(0, 0, 0, 3);
    rst_n = 1;
    drive(0, 0, 0, 4);
    tag = "R3";
    drive(0, 0, 1, 1);
    drive(0, 0, 0, R + 3);
    tag = "R4";
    for (int n = 1; n <= F + 3; n++) begin
      drive(1, 0, 0, n);
      drive(0, 0, 0, R + 3);
    end
    tag = "R5";
    for (int m = 1; m <= R + 2; m++) begin
      drive(1, 0, 0, F + 2);
      drive(0, 0, 0, m);
      drive(1, 0, 0, 1);
      drive(0, 0, 0, R + 3);
    end
    tag = "R2";
    drive(0, 1, 1, 3);
    drive(0, 0, 0, R + 3);
    start_up();
    drive(1, 0, 0, 2);
    drive(1, 1, 0, 1);
    drive(0, 0, 0, 3);
    start_up();
    drive(1, 0, 0, F + 2);
    drive(1, 1, 0, 1);
    start_up();
    drive(1, 0, 0, F + 2);
    drive(0, 0, 0, R / 2);
    drive(0, 1, 0, 1);
    drive(0, 0, 0, 4);
    tag = "R3";
    drive(0, 0, 1, 1);
    drive(0, 0, 0, R / 2);
    drive(0, 1, 0, 1);
    start_up();
    tag = "R6";
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        bit w, f, r;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        w = (lf[3:0] < 4'd5);
        f = (lf[9:4] == 6'd0);
        r = (lf[12:10] == 3'd1) && !w;
        drive(w, f, r, 1 + (lf[15:14] == 2'b11 ? 3 : 0));
      end
    end
    drive(0, 0, 0, 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule